// File: doc/BRIEF.md
# Seconds Counter With Alarm

A register-mapped timekeeping peripheral. It holds a 32-bit seconds count that advances on a slow seconds strobe, compares the advanced count with a 32-bit alarm word, and keeps two event flags: one for every second and one for the alarm match. Each flag has its own interrupt enable. The block drives a single interrupt line. A spare 32-bit storage word is also provided.

Software reaches the block over a simple word-indexed bus with select, write, index, write data and read data. Writes are posted. An accepted write is held in a holding stage and is applied after a fixed number of clock cycles, which models the hand-off into the slow timekeeping domain. A write-ready status bit reads 0 during that window. The seconds strobe arrives asynchronously and is passed through a synchronizer with edge detection, so each strobe produces exactly one count step.

Word index map: 0 control, 1 seconds count, 2 alarm seconds, 3 spare word. The index order matches the byte offsets 0x00, 0x04, 0x08 and 0x0C. Control word bits: 0 count enable, 2 alarm enable, 3 alarm interrupt enable, 4 alarm flag, 5 second interrupt enable, 6 second flag, 7 write-ready (read-only). All other bits read 0.

Top module: `rtc_seconds_alarm`

## Requirements
- R1: After reset the control word reads 0x00000080, the count, alarm and spare words read 0, and `irq` is 0.
- R2: An accepted write (select, write and write-ready all 1) makes write-ready read 0 for exactly WR_DELAY (default 4) cycles. The new value becomes readable in the cycle in which write-ready returns to 1, and not earlier.
- R3: A write issued while write-ready is 0 is ignored and leaves every register unchanged.
- R4: While count enable (bit 0) is 1, each seconds strobe adds one to the count. While it is 0, the count holds.
- R5: A seconds strobe with count enable set sets the second flag (bit 6). With count enable clear, the strobe does not set it.
- R6: The alarm flag (bit 4) is set by a strobe whose incremented count equals the alarm word, but only while alarm enable (bit 2) is 1.
- R7: Writing 0 to a flag bit clears that flag. Writing 1 leaves the flag unchanged, and a flag that is 0 stays 0.
- R8: `irq` is 1 exactly when (second flag and bit 5) or (alarm flag and bit 3) is true.
- R9: The count is an unsigned 32-bit value, so 0xFFFFFFFF steps to 0x00000000.
- R10: The spare word stores and returns any 32-bit value and has no side effects.
- R11: Bit 7 ignores written data. Bits 1 and 31:8 read 0.
- R12: The count changes only on a strobe or on a committed write, so two reads between strobes return the same value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Access select |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_idx | input | 2 | Word index (0 control, 1 count, 2 alarm, 3 spare) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the word at bus_idx (combinational) |
| sec_tick | input | 1 | Asynchronous seconds strobe |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that the seconds strobe stays at each level long enough for the synchronizer to see it. They also assume that bus controls are stable around the clock edge. The stimulus drives every input on the falling edge. It holds each strobe high for a full cycle and then leaves several idle cycles before the next one. Software polls write-ready before every write, except in the one test that deliberately writes during the busy window.

// File: rtl/rtc_pkg.sv
// Shared word indices and control-bit positions for the seconds counter.
// Assumes a 32-bit data path; the positions are decoded by software.
package rtc_pkg;
    localparam int unsigned IDX_W     = 2;
    localparam logic [1:0] IDX_CTRL   = 2'd0;
    localparam logic [1:0] IDX_COUNT  = 2'd1;
    localparam logic [1:0] IDX_ALARM  = 2'd2;
    localparam logic [1:0] IDX_SPARE  = 2'd3;

    localparam int unsigned B_RUN     = 0;
    localparam int unsigned B_ALM_EN  = 2;
    localparam int unsigned B_ALM_IE  = 3;
    localparam int unsigned B_ALM_FLG = 4;
    localparam int unsigned B_SEC_IE  = 5;
    localparam int unsigned B_SEC_FLG = 6;
    localparam int unsigned B_WRDY    = 7;

    typedef struct packed {
        logic run;
        logic alm_en;
        logic alm_ie;
        logic alm_flg;
        logic sec_ie;
        logic sec_flg;
    } ctrl_t;
endpackage

// File: rtl/rtc_tick_sync.sv
// Brings the asynchronous seconds strobe into the clock domain and emits a
// one-cycle pulse per rising edge. Assumes each strobe level lasts at least
// one clock period.
module rtc_tick_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_async,
    output logic tick_pulse
);
    localparam int unsigned CHAIN = STAGES + 1;

    logic [CHAIN-1:0] chain_q;

    // Shift the strobe through the synchronizer and one edge-detect stage.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[CHAIN-2:0], tick_async};
    end

    assign tick_pulse = chain_q[CHAIN-2] & ~chain_q[CHAIN-1];

    a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        tick_pulse |=> !tick_pulse);
endmodule

// File: rtl/rtc_wr_post.sv
// Accepts bus writes while ready, holds them for WR_DELAY cycles to model
// the slow-domain hand-off, then issues a one-cycle commit. Assumes
// WR_DELAY >= 1; writes arriving while busy are dropped.
module rtc_wr_post #(
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned IDX_W    = 2,
    parameter int unsigned WR_DELAY = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_sel,
    input  logic              req_wr,
    input  logic [IDX_W-1:0]  req_idx,
    input  logic [DATA_W-1:0] req_data,
    output logic              wr_ready,
    output logic              cm_valid,
    output logic [IDX_W-1:0]  cm_idx,
    output logic [DATA_W-1:0] cm_data
);
    localparam int unsigned CNT_W = $clog2(WR_DELAY + 1);
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(WR_DELAY);

    logic [CNT_W-1:0] busy_q;
    logic             accept;

    assign accept   = req_sel & req_wr & wr_ready;
    assign wr_ready = (busy_q == '0);
    assign cm_valid = (busy_q == CNT_W'(1));

    // Count down the posting window after each accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n)           busy_q <= '0;
        else if (accept)      busy_q <= LOAD;
        else if (!wr_ready)   busy_q <= busy_q - CNT_W'(1);
    end

    // Capture the index and data of the accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cm_idx  <= '0;
            cm_data <= '0;
        end else if (accept) begin
            cm_idx  <= req_idx;
            cm_data <= req_data;
        end
    end

    a_r2_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !wr_ready);
    a_r3_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ready |=> $stable(cm_data) && $stable(cm_idx));
    a_r2_commit_once: assert property (@(posedge clk) disable iff (!rst_n)
        cm_valid |=> wr_ready);
endmodule

// File: rtl/rtc_core.sv
// Seconds count, alarm compare, control bits and spare word. Applies
// committed writes; a write to the count takes priority over a strobe.
// Flags are cleared only by writing 0; ones written to them are ignored.
module rtc_core
    import rtc_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              cm_valid,
    input  logic [IDX_W-1:0]  cm_idx,
    input  logic [DATA_W-1:0] cm_data,
    output ctrl_t             ctrl,
    output logic [DATA_W-1:0] count,
    output logic [DATA_W-1:0] alarm,
    output logic [DATA_W-1:0] spare
);
    logic [DATA_W-1:0] count_inc;
    logic              step;
    logic              hit;
    logic              wr_ctrl, wr_count, wr_alarm, wr_spare;

    assign count_inc = count + DATA_W'(1);
    assign step      = tick & ctrl.run;
    assign hit       = step & ctrl.alm_en & (count_inc == alarm);
    assign wr_ctrl   = cm_valid & (cm_idx == IDX_CTRL);
    assign wr_count  = cm_valid & (cm_idx == IDX_COUNT);
    assign wr_alarm  = cm_valid & (cm_idx == IDX_ALARM);
    assign wr_spare  = cm_valid & (cm_idx == IDX_SPARE);

    // Advance or load the seconds count.
    always_ff @(posedge clk) begin
        if (!rst_n)        count <= '0;
        else if (wr_count) count <= cm_data;
        else if (step)     count <= count_inc;
    end

    // Load the alarm and spare words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alarm <= '0;
            spare <= '0;
        end else begin
            if (wr_alarm) alarm <= cm_data;
            if (wr_spare) spare <= cm_data;
        end
    end

    // Update enables from writes; set flags on events, clear on written 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= '0;
        end else begin
            if (wr_ctrl) begin
                ctrl.run    <= cm_data[B_RUN];
                ctrl.alm_en <= cm_data[B_ALM_EN];
                ctrl.alm_ie <= cm_data[B_ALM_IE];
                ctrl.sec_ie <= cm_data[B_SEC_IE];
            end
            ctrl.sec_flg <= step |
                (ctrl.sec_flg & ~(wr_ctrl & ~cm_data[B_SEC_FLG]));
            ctrl.alm_flg <= hit |
                (ctrl.alm_flg & ~(wr_ctrl & ~cm_data[B_ALM_FLG]));
        end
    end

    a_r12_stable_between: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !wr_count) |=> $stable(count));
    a_r4_step_one: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && ctrl.run && !wr_count) |=> count == $past(count) + DATA_W'(1));
    a_r6_alarm_gated: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctrl.alm_flg) |-> $past(ctrl.alm_en) && $past(tick));
    a_r5_flag_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctrl.sec_flg) |-> $past(ctrl.run));
endmodule

// File: rtl/rtc_seconds_alarm.sv
// Top level of the seconds counter with alarm: ties the strobe
// synchronizer, write posting stage and core together, and forms the read
// mux and interrupt. Assumes bus inputs are synchronous to clk.
module rtc_seconds_alarm
    import rtc_pkg::*;
#(
    parameter int unsigned DATA_W      = 32,
    parameter int unsigned WR_DELAY    = 4,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [1:0]        bus_idx,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              sec_tick,
    output logic              irq
);
    logic              tick_pulse;
    logic              wr_ready;
    logic              cm_valid;
    logic [IDX_W-1:0]  cm_idx;
    logic [DATA_W-1:0] cm_data;
    ctrl_t             ctrl;
    logic [DATA_W-1:0] count, alarm, spare;
    logic [DATA_W-1:0] ctrl_word;

    rtc_tick_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .tick_async(sec_tick), .tick_pulse(tick_pulse)
    );

    rtc_wr_post #(.DATA_W(DATA_W), .IDX_W(IDX_W), .WR_DELAY(WR_DELAY)) u_post (
        .clk(clk), .rst_n(rst_n), .req_sel(bus_sel), .req_wr(bus_wr),
        .req_idx(bus_idx), .req_data(bus_wdata), .wr_ready(wr_ready),
        .cm_valid(cm_valid), .cm_idx(cm_idx), .cm_data(cm_data)
    );

    rtc_core #(.DATA_W(DATA_W)) u_core (
        .clk(clk), .rst_n(rst_n), .tick(tick_pulse), .cm_valid(cm_valid),
        .cm_idx(cm_idx), .cm_data(cm_data), .ctrl(ctrl), .count(count),
        .alarm(alarm), .spare(spare)
    );

    // Assemble the control word as software sees it.
    always_comb begin
        ctrl_word            = '0;
        ctrl_word[B_RUN]     = ctrl.run;
        ctrl_word[B_ALM_EN]  = ctrl.alm_en;
        ctrl_word[B_ALM_IE]  = ctrl.alm_ie;
        ctrl_word[B_ALM_FLG] = ctrl.alm_flg;
        ctrl_word[B_SEC_IE]  = ctrl.sec_ie;
        ctrl_word[B_SEC_FLG] = ctrl.sec_flg;
        ctrl_word[B_WRDY]    = wr_ready;
    end

    // Select the word addressed by the bus index.
    always_comb begin
        case (bus_idx)
            IDX_CTRL:  bus_rdata = ctrl_word;
            IDX_COUNT: bus_rdata = count;
            IDX_ALARM: bus_rdata = alarm;
            default:   bus_rdata = spare;
        endcase
    end

    assign irq = (ctrl.sec_flg & ctrl.sec_ie) | (ctrl.alm_flg & ctrl.alm_ie);

    a_r8_irq_has_source: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (ctrl.sec_flg || ctrl.alm_flg));
    a_r11_ro_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_idx == IDX_CTRL) |-> (bus_rdata[DATA_W-1:8] == '0) && !bus_rdata[1]);
endmodule

// File: tb/rtc_seconds_alarm_test.sv
module rtc_seconds_alarm_test;
    localparam int CLK_PERIOD = 10;
    localparam int WR_DELAY   = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [1:0]  bus_idx = 2'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        sec_tick = 1'b0;
    logic        irq;

    int checks = 0;
    int errors = 0;

    // {index, data}: write then read back (R10, R11, R2)
    localparam logic [33:0] VEC [6] = '{
        {2'd3, 32'hA5A5_5A5A},
        {2'd3, 32'h0000_0000},
        {2'd2, 32'hDEAD_BEEF},
        {2'd1, 32'h1234_5678},
        {2'd0, 32'hFFFF_FFFF},
        {2'd0, 32'h0000_0000}
    };

    rtc_seconds_alarm #(.WR_DELAY(WR_DELAY)) uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_idx(bus_idx), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sec_tick(sec_tick), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] idx, output logic [31:0] val);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_idx = idx;
        #1 val = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic wait_ready();
        logic [31:0] v;
        v = '0;
        while (v[7] !== 1'b1) rd(2'd0, v);
    endtask

    task automatic wr_raw(input logic [1:0] idx, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_idx = idx; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic wr(input logic [1:0] idx, input logic [31:0] d);
        wait_ready();
        wr_raw(idx, d);
        wait_ready();
    endtask

    task automatic tick();
        @(negedge clk) sec_tick = 1'b1;
        @(negedge clk) sec_tick = 1'b0;
        repeat (5) @(negedge clk);
    endtask

    task automatic check_reset(input string tag);
        logic [31:0] v;
        rd(2'd0, v); check({tag, " ctrl"}, v, 32'h80);
        rd(2'd1, v); check({tag, " count"}, v, 32'h0);
        rd(2'd2, v); check({tag, " alarm"}, v, 32'h0);
        rd(2'd3, v); check({tag, " spare"}, v, 32'h0);
        check({tag, " irq"}, {31'b0, irq}, 32'h0);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        logic [31:0] v, v2, expv;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check_reset("R1");

        // Table walk: write, read back (R10 spare, R11 ctrl masking)
        foreach (VEC[i]) begin
            wr(VEC[i][33:32], VEC[i][31:0]);
            rd(VEC[i][33:32], v);
            expv = (VEC[i][33:32] == 2'd0) ? ((VEC[i][31:0] & 32'h2D) | 32'h80)
                                            : VEC[i][31:0];
            check("R10/R11 table readback", v, expv);
        end

        // R2: ready low for exactly WR_DELAY cycles; value lands on rise
        wait_ready();
        wr_raw(2'd3, 32'h0BAD_F00D);
        for (int k = 1; k <= WR_DELAY; k++) begin
            @(negedge clk);
            bus_sel = 1'b1; bus_wr = 1'b0; bus_idx = 2'd0;
            #1 v = bus_rdata;
            if (k < WR_DELAY) begin
                check("R2 ready low", {31'b0, v[7]}, 32'h0);
                bus_idx = 2'd3;
                #1 check("R2 not yet visible", bus_rdata, 32'h0);
            end else begin
                check("R2 ready back", {31'b0, v[7]}, 32'h1);
                bus_idx = 2'd3;
                #1 check("R2 visible", bus_rdata, 32'h0BAD_F00D);
            end
            bus_sel = 1'b0;
        end

        // R3: write during busy window dropped
        wait_ready();
        wr_raw(2'd2, 32'h1111_1111);
        wr_raw(2'd2, 32'h2222_2222);
        wait_ready();
        rd(2'd2, v); check("R3 busy write ignored", v, 32'h1111_1111);

        // R4/R5/R6/R8: alarm match with enables
        wr(2'd1, 32'd9);
        wr(2'd2, 32'd10);
        wr(2'd0, 32'h0D);
        tick();
        rd(2'd1, v); check("R4 increment", v, 32'd10);
        rd(2'd1, v2); check("R12 stable reads", v2, v);
        rd(2'd0, v); check("R5/R6 flags set", v, 32'hDD);
        check("R8 irq alarm", {31'b0, irq}, 32'h1);

        // R7: clear alarm flag with 0, keep second flag with 1
        wr(2'd0, 32'h4D);
        rd(2'd0, v); check("R7 selective clear", v, 32'hCD);
        check("R8 irq off", {31'b0, irq}, 32'h0);
        wr(2'd0, 32'h6D);
        check("R8 irq second", {31'b0, irq}, 32'h1);
        wr(2'd0, 32'h2D);
        rd(2'd0, v); check("R7 clear second", v, 32'hAD);
        check("R8 irq cleared", {31'b0, irq}, 32'h0);

        // R6: no alarm flag when alarm enable clear
        wr(2'd1, 32'd19);
        wr(2'd2, 32'd20);
        wr(2'd0, 32'h09);
        tick();
        rd(2'd0, v); check("R6 alarm disabled", v, 32'hC9);
        check("R8 no irq", {31'b0, irq}, 32'h0);

        // R4/R5: counter disabled holds, no flag
        wr(2'd0, 32'h00);
        tick();
        rd(2'd1, v); check("R4 hold when off", v, 32'd20);
        rd(2'd0, v); check("R5 no flag when off", v, 32'h80);

        // R9: wrap
        wr(2'd1, 32'hFFFF_FFFF);
        wr(2'd0, 32'h01);
        tick();
        rd(2'd1, v); check("R9 wrap", v, 32'h0);
        tick();
        rd(2'd1, v); check("R4 second step", v, 32'h1);

        // R1: mid-run reset
        wr(2'd3, 32'h55);
        @(negedge clk) rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        check_reset("R1 rerun");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule